// File: doc/BRIEF.md
# Byte-Wide Host FIFO Bridge Controller

This controller sits in an FPGA and moves bytes between local logic and an external byte-wide USB FIFO device. It uses the device's asynchronous parallel interface. The device reports its state on two active-low flags. The space flag says whether the device can take another byte for the host. The data flag says whether the device's receive buffer still holds unread bytes. The controller drives the device's active-low read and write strobes and the shared 8-bit data bus. The bus is split at this level into an input, an output and an output enable. The tristate pad itself sits outside the block.

On the local side there are two streams. The transmit stream accepts a byte only when the device has latched that byte: `tx_ready` pulses in the last cycle of the write strobe. Until then, the source must hold `tx_valid` and `tx_data` steady. The receive stream presents one captured byte on `rx_data` with `rx_valid` high. That byte stays unchanged until `rx_ready` is seen. While the byte waits, no further read is started, so back-pressure on the receive side stalls the device reads and loses nothing.

Both flags pass through two-flop synchronizers. The space flag pulses inactive after every latched byte. It may also dip low for a short time while the device is still full. For these reasons, a write needs the synchronized space flag to have gone inactive since the last write and then to stay active for a programmable number of consecutive cycles. Reads are re-armed by the data flag in the same way. When both directions are ready, they take turns. Every read is followed by an idle turnaround cycle before the bus can be driven again.

Top module: `hfifo_bridge`

## Requirements
- R1: While reset is asserted, both strobes are high, the bus output enable is low, and `rx_valid` and `tx_ready` are low.
- R2: A write strobe falls only after the space flag has been low for at least SPACE_QUAL consecutive cycles, counted after the two-flop synchronizer.
- R3: After each write strobe, no new write begins until the space flag has been seen high and then low again.
- R4: While the space flag stays high, the transmit stream stalls with no time limit. A short low dip of fewer than SPACE_QUAL cycles does not cause a write. Every offered byte reaches the device once, in order.
- R5: A read strobe falls only while the data flag is low, and only if that flag has been seen high since the previous read. Every device byte is delivered once, in order. A stale bus value is never captured.
- R6: `dev_bus_oe` is never high while `dev_rd_n` is low.
- R7: At least two cycles with `dev_rd_n` high pass between the end of a read strobe and the next rise of `dev_bus_oe`.
- R8: While `rx_valid` is high and `rx_ready` is low, `rx_valid` stays high and `rx_data` stays unchanged in the next cycle.
- R9: `tx_ready` is high only in the final low cycle of a write strobe. When the strobe rises, `dev_bus_oe` is high and `dev_bus_out` carries the accepted byte.
- R10: The write strobe stays low for exactly WR_LO cycles and the read strobe for exactly RD_LO cycles. Read data is captured at the end of the read strobe's low period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 8 | Byte offered for transmission to the host |
| tx_valid | input | 1 | Transmit byte is valid; held until accepted |
| tx_ready | output | 1 | Byte accepted; the write strobe is completing |
| rx_data | output | 8 | Byte read from the device |
| rx_valid | output | 1 | Receive byte is present |
| rx_ready | input | 1 | Local sink accepts the receive byte |
| dev_space_n | input | 1 | Device flag, low when a byte can be written (asynchronous) |
| dev_avail_n | input | 1 | Device flag, low when unread data remains (asynchronous) |
| dev_rd_n | output | 1 | Active-low read strobe |
| dev_wr_n | output | 1 | Active-low write strobe |
| dev_bus_in | input | 8 | Data bus value seen from the device |
| dev_bus_out | output | 8 | Data bus value driven toward the device |
| dev_bus_oe | output | 1 | Bus output enable |

## Verification
The assertions rely on a few properties of the device and the local source.

- The device raises each flag after every byte it exchanges.
- The device changes the bus only while the read strobe is low.
- The local source keeps `tx_valid` and `tx_data` steady until `tx_ready`.

The bench's device model raises the matching flag at the first sample after each strobe rises and holds it high for one to three cycles. It presents the next byte as soon as the read strobe is seen low. It injects two-cycle false dips on the space flag only while its buffer is full. The transmit driver never withdraws or changes a byte it has offered.

// File: rtl/hfb_pkg.sv
package hfb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_LO,
    ST_WR_HI,
    ST_RD_LO,
    ST_RD_HI,
    ST_TURN
  } xfer_st_e;

  function automatic int unsigned max_of4(int unsigned a, int unsigned b,
                                          int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/hfb_sync.sv
module hfb_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/hfb_flag_qual.sv
module hfb_flag_qual #(
  parameter int unsigned QUAL_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_n,
  input  logic op_done,
  output logic ok
);

  localparam int unsigned CW = $clog2(QUAL_CYC + 1);

  logic [CW-1:0] low_cnt_q;
  logic          need_high_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q   <= '0;
      need_high_q <= 1'b0;
    end else begin
      if (flag_n || op_done)                low_cnt_q <= '0;
      else if (low_cnt_q != CW'(QUAL_CYC))  low_cnt_q <= low_cnt_q + 1'b1;

      if (op_done)     need_high_q <= 1'b1;
      else if (flag_n) need_high_q <= 1'b0;
    end
  end

  assign ok = !need_high_q && !flag_n && (low_cnt_q == CW'(QUAL_CYC));

  // R3
  rearm_after_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !ok);

endmodule

// File: rtl/hfb_xfer_seq.sv
module hfb_xfer_seq
  import hfb_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned WR_LO = 2,
  parameter int unsigned WR_HI = 2,
  parameter int unsigned RD_LO = 3,
  parameter int unsigned RD_HI = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  input  logic          space_ok,
  input  logic          avail_ok,
  output logic          wr_done,
  output logic          rd_done,
  output logic          dev_rd_n,
  output logic          dev_wr_n,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe
);

  localparam int unsigned MAXC = max_of4(WR_LO, WR_HI, RD_LO, RD_HI);
  localparam int unsigned TW   = (MAXC > 1) ? $clog2(MAXC) : 1;

  xfer_st_e      state_q, state_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          last_rd_q;
  logic          grant_wr, grant_rd;
  logic          want_wr, want_rd;
  logic [DW-1:0] wr_byte_q;
  logic [DW-1:0] rx_hold_q;
  logic          rx_full_q;
  logic          wr_n_q, rd_n_q, oe_q;

  assign want_wr = tx_valid && space_ok;
  assign want_rd = avail_ok && !rx_full_q;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    grant_wr = 1'b0;
    grant_rd = 1'b0;
    wr_done  = 1'b0;
    rd_done  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (want_wr && (!want_rd || last_rd_q)) begin
          grant_wr = 1'b1;
          state_d  = ST_WR_LO;
          cnt_d    = TW'(WR_LO - 1);
        end else if (want_rd) begin
          grant_rd = 1'b1;
          state_d  = ST_RD_LO;
          cnt_d    = TW'(RD_LO - 1);
        end
      end
      ST_WR_LO: begin
        if (cnt_q == '0) begin
          wr_done = 1'b1;
          state_d = ST_WR_HI;
          cnt_d   = TW'(WR_HI - 1);
        end else cnt_d = cnt_q - 1'b1;
      end
      ST_WR_HI: begin
        if (cnt_q == '0) state_d = ST_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_RD_LO: begin
        if (cnt_q == '0) begin
          rd_done = 1'b1;
          state_d = ST_RD_HI;
          cnt_d   = TW'(RD_HI - 1);
        end else cnt_d = cnt_q - 1'b1;
      end
      ST_RD_HI: begin
        if (cnt_q == '0) state_d = ST_TURN;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_TURN: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      last_rd_q <= 1'b0;
      wr_byte_q <= '0;
      rx_hold_q <= '0;
      rx_full_q <= 1'b0;
      wr_n_q    <= 1'b1;
      rd_n_q    <= 1'b1;
      oe_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (grant_wr) begin
        last_rd_q <= 1'b0;
        wr_byte_q <= tx_data;
      end else if (grant_rd) begin
        last_rd_q <= 1'b1;
      end
      if (rd_done) begin
        rx_hold_q <= bus_in;
        rx_full_q <= 1'b1;
      end else if (rx_ready) begin
        rx_full_q <= 1'b0;
      end
      wr_n_q <= (state_d != ST_WR_LO);
      rd_n_q <= (state_d != ST_RD_LO);
      oe_q   <= (state_d == ST_WR_LO) || (state_d == ST_WR_HI);
    end
  end

  assign tx_ready = wr_done;
  assign rx_data  = rx_hold_q;
  assign rx_valid = rx_full_q;
  assign dev_wr_n = wr_n_q;
  assign dev_rd_n = rd_n_q;
  assign bus_oe   = oe_q;
  assign bus_out  = wr_byte_q;

  // R2
  write_needs_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_wr_n) |-> $past(space_ok));

  // R5
  read_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_rd_n) |-> $past(avail_ok));

  // R6
  no_drive_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_rd_n |-> !bus_oe);

  // R7
  read_turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> ($past(dev_rd_n) && $past(dev_rd_n, 2)));

  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R9
  tx_accept_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !dev_wr_n);

  // R9
  tx_accept_ends_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> (dev_wr_n && bus_oe));

endmodule

// File: rtl/hfifo_bridge.sv
module hfifo_bridge #(
  parameter int unsigned WR_LO      = 2,
  parameter int unsigned WR_HI      = 2,
  parameter int unsigned RD_LO      = 3,
  parameter int unsigned RD_HI      = 2,
  parameter int unsigned SPACE_QUAL = 4,
  parameter int unsigned AVAIL_QUAL = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       rx_ready,
  input  logic       dev_space_n,
  input  logic       dev_avail_n,
  output logic       dev_rd_n,
  output logic       dev_wr_n,
  input  logic [7:0] dev_bus_in,
  output logic [7:0] dev_bus_out,
  output logic       dev_bus_oe
);

  localparam int unsigned NFLAG = 2;

  logic [NFLAG-1:0] flags_s;
  logic             space_ok, avail_ok;
  logic             wr_done, rd_done;

  hfb_sync #(.WIDTH(NFLAG), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({dev_avail_n, dev_space_n}),
    .sync_o  (flags_s)
  );

  hfb_flag_qual #(.QUAL_CYC(SPACE_QUAL)) u_space_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .flag_n  (flags_s[0]),
    .op_done (wr_done),
    .ok      (space_ok)
  );

  hfb_flag_qual #(.QUAL_CYC(AVAIL_QUAL)) u_avail_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .flag_n  (flags_s[1]),
    .op_done (rd_done),
    .ok      (avail_ok)
  );

  hfb_xfer_seq #(
    .DW(8), .WR_LO(WR_LO), .WR_HI(WR_HI), .RD_LO(RD_LO), .RD_HI(RD_HI)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .space_ok (space_ok),
    .avail_ok (avail_ok),
    .wr_done  (wr_done),
    .rd_done  (rd_done),
    .dev_rd_n (dev_rd_n),
    .dev_wr_n (dev_wr_n),
    .bus_in   (dev_bus_in),
    .bus_out  (dev_bus_out),
    .bus_oe   (dev_bus_oe)
  );

endmodule

// File: tb/hfifo_bridge_tb_top.sv
module hfifo_bridge_tb_top;

  localparam int WR_LO = 2, WR_HI = 2, RD_LO = 3, RD_HI = 2;
  localparam int SPACE_QUAL = 4, AVAIL_QUAL = 1;
  localparam int NTX = 200, NRX = 200, CAP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic tx_ready;
  logic [7:0] rx_data;
  logic rx_valid;
  logic rx_ready = 1'b0;
  logic dev_space_n = 1'b1;
  logic dev_avail_n = 1'b1;
  logic dev_rd_n, dev_wr_n;
  logic [7:0] dev_bus_in = '0;
  logic [7:0] dev_bus_out;
  logic dev_bus_oe;

  always #10 clk = ~clk;

  hfifo_bridge #(
    .WR_LO(WR_LO), .WR_HI(WR_HI), .RD_LO(RD_LO), .RD_HI(RD_HI),
    .SPACE_QUAL(SPACE_QUAL), .AVAIL_QUAL(AVAIL_QUAL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .dev_space_n(dev_space_n), .dev_avail_n(dev_avail_n),
    .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n),
    .dev_bus_in(dev_bus_in), .dev_bus_out(dev_bus_out), .dev_bus_oe(dev_bus_oe)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] tx_byte(input int i);
    return 8'((i * 29 + 7) ^ (i >> 3));
  endfunction

  function automatic logic [7:0] rx_byte(input int i);
    return 8'(i * 53 + 17);
  endfunction

  // bench control
  bit drain_en = 1'b1, glitch_en = 1'b0, rx_bp = 1'b0;
  int cyc = 0;
  // device and stream state
  logic [7:0] dev_q[$];
  int host_n = 0, dev_wr_cnt = 0, tx_idx = 0, hs_cnt = 0;
  int rx_idx = 0, local_n = 0;

  initial begin : traffic
    int seed;
    bit prev_wr, prev_rd, prev_oe, prev_txr, prev_rxv, prev_rxr, tx_pend;
    logic [7:0] prev_rxd;
    int sp_run, av_run, rd_since, wr_len, rd_len, gap, rgap, glitch;
    bit sp_seen_hi, av_seen_hi;
    seed = $urandom(32'd1234);
    prev_wr = 1; prev_rd = 1; prev_oe = 0; prev_txr = 0;
    prev_rxv = 0; prev_rxr = 0; prev_rxd = '0; tx_pend = 0;
    sp_run = 0; av_run = 0; rd_since = 100; wr_len = 0; rd_len = 0;
    gap = 0; rgap = 0; glitch = 0; sp_seen_hi = 1; av_seen_hi = 1;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        // R6: no drive during read
        if (!dev_rd_n) chk(!dev_bus_oe, "R6", dev_bus_oe, 0);
        // write strobe falling: R2, R3
        if (prev_wr && !dev_wr_n) begin
          chk(sp_run >= SPACE_QUAL + 1, "R2", sp_run, SPACE_QUAL + 1);
          chk(sp_seen_hi, "R3", sp_seen_hi, 1);
          wr_len = 1;
        end else if (!dev_wr_n) wr_len++;
        // read strobe falling: R5
        if (prev_rd && !dev_rd_n) begin
          chk(av_run >= AVAIL_QUAL && av_seen_hi, "R5", av_run, AVAIL_QUAL);
          rd_len = 1;
          if (rx_idx < NRX) dev_bus_in = rx_byte(rx_idx);
        end else if (!dev_rd_n) rd_len++;
        // R7: turnaround before driving
        if (!prev_oe && dev_bus_oe) chk(rd_since >= 2, "R7", rd_since, 2);
        // R9: tx_ready only inside the strobe
        if (tx_ready) chk(!dev_wr_n, "R9", dev_wr_n, 0);
        // flag history update
        sp_run = dev_space_n ? 0 : sp_run + 1;
        if (dev_space_n) sp_seen_hi = 1;
        av_run = dev_avail_n ? 0 : av_run + 1;
        if (dev_avail_n) av_seen_hi = 1;
        rd_since = dev_rd_n ? rd_since + 1 : 0;
        // write strobe rising: device latches
        if (!prev_wr && dev_wr_n) begin
          chk(wr_len == WR_LO, "R10", wr_len, WR_LO);
          chk(prev_txr, "R9", prev_txr, 1);
          chk(dev_bus_oe && dev_bus_out == tx_byte(dev_wr_cnt), "R9",
              dev_bus_out, tx_byte(dev_wr_cnt));
          if (dev_q.size() >= CAP) chk(0, "R4", dev_q.size(), CAP - 1);
          else dev_q.push_back(dev_bus_out);
          dev_wr_cnt++;
          sp_seen_hi = 0;
          gap = 1 + int'($urandom % 3);
        end
        // read strobe rising: device pops
        if (!prev_rd && dev_rd_n) begin
          chk(rd_len == RD_LO, "R10", rd_len, RD_LO);
          if (rx_idx >= NRX) chk(0, "R5", rx_idx, NRX - 1);
          else rx_idx++;
          av_seen_hi = 0;
          rgap = 1 + int'($urandom % 3);
        end
        // host drains the device buffer
        if (drain_en && dev_q.size() > 0 && ($urandom % 3) == 0) begin
          logic [7:0] b;
          b = dev_q.pop_front();
          // R4: order and uniqueness
          chk(b == tx_byte(host_n), "R4", b, tx_byte(host_n));
          host_n++;
        end
        // space flag model
        if (gap > 0) begin dev_space_n = 1; gap--; end
        else if (glitch > 0) begin dev_space_n = 0; glitch--; end
        else begin
          dev_space_n = (dev_q.size() >= CAP);
          if (dev_space_n && glitch_en && ($urandom % 25) == 0) glitch = 2;
        end
        // data flag model
        if (rgap > 0) begin dev_avail_n = 1; rgap--; end
        else dev_avail_n = (rx_idx >= NRX);
        // receive stream: R8 hold, then accept
        if (prev_rxv && !prev_rxr)
          chk(rx_valid && rx_data == prev_rxd, "R8", rx_data, prev_rxd);
        rx_ready = !rx_bp && (($urandom % 4) != 0);
        if (rx_valid && rx_ready) begin
          // R5: captured bytes match the device stream
          chk(rx_data == rx_byte(local_n), "R5", rx_data, rx_byte(local_n));
          local_n++;
        end
        prev_rxv = rx_valid; prev_rxr = rx_ready; prev_rxd = rx_data;
        // transmit stream driver
        if (tx_pend) begin
          tx_idx++; hs_cnt++; tx_valid = 0; tx_pend = 0;
        end
        if (!tx_valid && tx_idx < NTX && ($urandom % 4) != 0) begin
          tx_valid = 1; tx_data = tx_byte(tx_idx);
        end
        tx_pend = tx_valid && tx_ready;
        prev_txr = tx_ready;
        prev_wr = dev_wr_n; prev_rd = dev_rd_n; prev_oe = dev_bus_oe;
      end
    end
  end

  initial begin : main
    int hs_mark, loc_mark;
    bit timed_out;
    timed_out = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(dev_wr_n == 1, "R1", dev_wr_n, 1);
    chk(dev_rd_n == 1, "R1", dev_rd_n, 1);
    chk(dev_bus_oe == 0, "R1", dev_bus_oe, 0);
    chk(rx_valid == 0 && tx_ready == 0, "R1", {rx_valid, tx_ready}, 0);
    rst_n = 1;
    repeat (500) @(negedge clk);
    // R4: directed stall with host not draining, false dips on the flag
    drain_en = 0; glitch_en = 1;
    repeat (400) @(negedge clk);
    hs_mark = hs_cnt;
    repeat (400) @(negedge clk);
    chk(dev_q.size() == CAP, "R4", dev_q.size(), CAP);
    chk(hs_cnt == hs_mark, "R4", hs_cnt, hs_mark);
    drain_en = 1; glitch_en = 0;
    // R8: receive back-pressure holds the byte and stops reads
    repeat (300) @(negedge clk);
    rx_bp = 1;
    repeat (50) @(negedge clk);
    loc_mark = rx_idx;
    repeat (200) @(negedge clk);
    chk(rx_idx == loc_mark, "R8", rx_idx, loc_mark);
    rx_bp = 0;
    while (!(host_n == NTX && local_n == NRX)) begin
      @(negedge clk);
      if (cyc > 150000) begin timed_out = 1; break; end
    end
    if (timed_out) chk(0, "watchdog", cyc, 150000);
    chk(host_n == NTX, "R4", host_n, NTX);
    chk(local_n == NRX, "R5", local_n, NRX);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule